// File: doc/BRIEF.md
# Flash Block Access Protection Unit

This unit sits between the on-chip program flash and everything that reaches it. For every request it decides, within the same cycle, whether the access goes ahead. It drives a grant bit and a read-data mask that forces read data to zero when a read is refused. A refused read raises no fault: it simply returns zeros.

User flash is split into a boot region and a number of equal numbered regions. Each region has three active-low protection bits:
- an external-lock bit, which blocks an outside programmer from reading or writing the region;
- a write-lock bit, which blocks internal table writes;
- a read-fence bit, which lets a table read succeed only if the instruction doing the read was fetched from inside the same region.

The protection bits live in a small configuration space. That space is read and written with the same table accesses as user memory, and it also holds a read-only device identifier. Written values are ANDed into the bits, so a bit only ever moves from one to zero. Bits return to one only through an erase command that comes from the external programming port.

The flash array, its programming timing and the serial programming protocol sit outside this unit.

Top module: `flash_guard`

## Requirements
- R1: The boot region covers addresses 0x0000 to 0x07FF and has region index 4. The numbered regions 0 to 3 follow from 0x0800, each 0x1E00 words long, ending at 0x7FFF. In every configuration byte, bit n belongs to numbered region n and bit 4 belongs to the boot region.
- R2: An internal table write (`acc_type_i`=1) to user memory is granted exactly when the write-lock bit of the target region is 1.
- R3: An internal table read (`acc_type_i`=0) to user memory is granted when the read-fence bit of the target region is 1. It is also granted when the region of `pc_i` equals the target region. Otherwise it is refused.
- R4: A granted read (`acc_type_i` 0 or 2) drives `rd_mask_o` to all ones. A refused read, any write, and any cycle with `req_i`=0 drive `rd_mask_o` to zero. `grant_o` is 0 whenever `req_i` is 0.
- R5: External-lock bits gate only external reads and writes (`acc_type_i` 2 or 3), which are granted exactly when the target region's bit is 1. They have no effect on internal table accesses.
- R6: Configuration space is selected by `cfg_sel_i`=1, and every access to it is granted. `addr_i[1:0]` selects the byte: 0 external-lock, 1 write-lock, 2 read-fence, 3 device identifier 0x5A. A write (`acc_type_i` 1 or 3) to bytes 0 to 2 sets that byte's bits to old AND `wdata_i`. A write to byte 3 has no effect. For reads, `cfg_rdata_o` shows the selected byte; otherwise it is 0.
- R7: When `erase_req_i` and `erase_ext_i` are both 1, the unit erases on the next edge. With `erase_all_i`=1 it sets every protection bit to 1. With `erase_all_i`=0 it sets the three bits of region `erase_blk_i` (0 to 4) to 1, and an index above 4 changes nothing.
- R8: An erase request with `erase_ext_i`=0 changes no protection bit.
- R9: Reset loads every protection bit with 1. Decisions are combinational in the request cycle, and bit updates appear after the next rising clock edge.
- R10: When an accepted erase and a configuration write fall in the same cycle, the erase wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request valid |
| acc_type_i | input | 2 | 0 table read, 1 table write, 2 external read, 3 external write |
| cfg_sel_i | input | 1 | 1 selects configuration space |
| addr_i | input | 15 | Access address (config byte in bits 1:0) |
| pc_i | input | 15 | Address of the instruction making the access |
| wdata_i | input | 5 | Configuration write value, one bit per region |
| erase_req_i | input | 1 | Erase command |
| erase_ext_i | input | 1 | 1 when the erase comes from the external port |
| erase_all_i | input | 1 | 1 full erase, 0 single-region erase |
| erase_blk_i | input | 3 | Region index for a single-region erase |
| grant_o | output | 1 | Access allowed |
| rd_mask_o | output | 16 | Read data mask, all ones or zero |
| cfg_rdata_o | output | 8 | Configuration byte read data |

## Verification
A protection bit that wrongly flips shows up at the ports as a changed grant on the first access that targets that region with the matching access type. A read of the configuration byte exposes it in the same cycle as that read. The bench therefore compares every cycle against a behavioural model, and after each update it reads the configuration bytes back directly. This catches a wrong value from a write, an erase or a reset one cycle after the edge that stored it. A region-boundary fault shows only at accesses that straddle a boundary, so directed reads sit on both sides of each edge, with the instruction address both inside and outside the fenced region.

// File: rtl/flg_pkg.sv
package flg_pkg;
  typedef enum logic [1:0] {
    ACC_TRD = 2'd0,
    ACC_TWR = 2'd1,
    ACC_XRD = 2'd2,
    ACC_XWR = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    CFG_XLK = 2'd0,
    CFG_WLK = 2'd1,
    CFG_RFN = 2'd2,
    CFG_ID  = 2'd3
  } cfg_off_e;

  localparam int unsigned NUM_KINDS = 3;
endpackage

// File: rtl/flg_region_dec.sv
module flg_region_dec #(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned N_BLK     = 4,
  parameter int unsigned BOOT_SIZE = 32'h0800,
  parameter int unsigned BLK_SIZE  = 32'h1E00,
  parameter int unsigned IDX_W     = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    idx_o = IDX_W'(N_BLK - 1);
    if (32'(addr_i) < BOOT_SIZE) begin
      idx_o = IDX_W'(N_BLK);
    end else begin
      for (int i = N_BLK - 1; i >= 0; i--) begin
        if (32'(addr_i) < BOOT_SIZE + (i + 1) * BLK_SIZE) idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/flg_prot_regs.sv
module flg_prot_regs
  import flg_pkg::*;
#(
  parameter int unsigned N_REG = 5,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  cfg_off_e         wr_sel_i,
  input  logic [N_REG-1:0] wr_data_i,
  input  logic             erase_ok_i,
  input  logic             erase_all_i,
  input  logic [IDX_W-1:0] erase_idx_i,
  output logic [N_REG-1:0] xlk_o,
  output logic [N_REG-1:0] wlk_o,
  output logic [N_REG-1:0] rfn_o
);
  logic [N_REG-1:0] bits_q [NUM_KINDS];
  logic [N_REG-1:0] erase_vec;

  always_comb begin
    erase_vec = '0;
    if (erase_all_i) erase_vec = '1;
    else if (32'(erase_idx_i) < N_REG) erase_vec[erase_idx_i] = 1'b1;
  end

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    logic [N_REG-1:0] nxt;
    always_comb begin
      nxt = bits_q[k];
      if (erase_ok_i) nxt = bits_q[k] | erase_vec;
      else if (wr_en_i && (wr_sel_i == cfg_off_e'(k))) nxt = bits_q[k] & wr_data_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bits_q[k] <= '1;
      else         bits_q[k] <= nxt;
    end
  end

  assign xlk_o = bits_q[0];
  assign wlk_o = bits_q[1];
  assign rfn_o = bits_q[2];

  logic [3*N_REG-1:0] all_q;
  assign all_q = {bits_q[2], bits_q[1], bits_q[0]};

  // R6
  one_way_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !erase_ok_i |=> ((all_q & ~$past(all_q)) == '0));

  // R7
  erase_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_ok_i && erase_all_i) |=> (&all_q));
endmodule

// File: rtl/flg_policy.sv
module flg_policy
  import flg_pkg::*;
#(
  parameter int unsigned N_REG = 5,
  parameter int unsigned IDX_W = 3
) (
  input  logic             req_i,
  input  acc_e             acc_i,
  input  logic             cfg_sel_i,
  input  logic [IDX_W-1:0] tgt_idx_i,
  input  logic [IDX_W-1:0] pc_idx_i,
  input  logic [N_REG-1:0] xlk_i,
  input  logic [N_REG-1:0] wlk_i,
  input  logic [N_REG-1:0] rfn_i,
  output logic             grant_o
);
  logic same_blk;
  assign same_blk = (tgt_idx_i == pc_idx_i);

  always_comb begin
    grant_o = 1'b0;
    if (req_i) begin
      if (cfg_sel_i) begin
        grant_o = 1'b1;
      end else begin
        unique case (acc_i)
          ACC_TRD: grant_o = rfn_i[tgt_idx_i] || same_blk;
          ACC_TWR: grant_o = wlk_i[tgt_idx_i];
          default: grant_o = xlk_i[tgt_idx_i];
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CFG_W     = 8,
  parameter int unsigned N_BLK     = 4,
  parameter int unsigned BOOT_SIZE = 32'h0800,
  parameter int unsigned BLK_SIZE  = 32'h1E00,
  parameter logic [7:0]  DEV_ID    = 8'h5A,
  localparam int unsigned N_REG    = N_BLK + 1,
  localparam int unsigned IDX_W    = $clog2(N_REG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        acc_type_i,
  input  logic              cfg_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [N_REG-1:0]  wdata_i,
  input  logic              erase_req_i,
  input  logic              erase_ext_i,
  input  logic              erase_all_i,
  input  logic [IDX_W-1:0]  erase_blk_i,
  output logic              grant_o,
  output logic [DATA_W-1:0] rd_mask_o,
  output logic [CFG_W-1:0]  cfg_rdata_o
);
  acc_e             acc;
  cfg_off_e         cfg_off;
  logic             is_rd, cfg_wr, erase_ok;
  logic [IDX_W-1:0] tgt_idx, pc_idx;
  logic [N_REG-1:0] xlk, wlk, rfn;

  assign acc     = acc_e'(acc_type_i);
  assign cfg_off = cfg_off_e'(addr_i[1:0]);
  assign is_rd   = (acc == ACC_TRD) || (acc == ACC_XRD);
  assign cfg_wr  = req_i && cfg_sel_i && !is_rd && (cfg_off != CFG_ID);
  // erases from user code never reach the bits
  assign erase_ok = erase_req_i && erase_ext_i;

  flg_region_dec #(.ADDR_W(ADDR_W), .N_BLK(N_BLK), .BOOT_SIZE(BOOT_SIZE),
                   .BLK_SIZE(BLK_SIZE), .IDX_W(IDX_W))
    u_tgt_dec (.addr_i(addr_i), .idx_o(tgt_idx));

  flg_region_dec #(.ADDR_W(ADDR_W), .N_BLK(N_BLK), .BOOT_SIZE(BOOT_SIZE),
                   .BLK_SIZE(BLK_SIZE), .IDX_W(IDX_W))
    u_pc_dec (.addr_i(pc_i), .idx_o(pc_idx));

  flg_prot_regs #(.N_REG(N_REG), .IDX_W(IDX_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (cfg_wr),
    .wr_sel_i    (cfg_off),
    .wr_data_i   (wdata_i),
    .erase_ok_i  (erase_ok),
    .erase_all_i (erase_all_i),
    .erase_idx_i (erase_blk_i),
    .xlk_o       (xlk),
    .wlk_o       (wlk),
    .rfn_o       (rfn)
  );

  flg_policy #(.N_REG(N_REG), .IDX_W(IDX_W)) u_policy (
    .req_i     (req_i),
    .acc_i     (acc),
    .cfg_sel_i (cfg_sel_i),
    .tgt_idx_i (tgt_idx),
    .pc_idx_i  (pc_idx),
    .xlk_i     (xlk),
    .wlk_i     (wlk),
    .rfn_i     (rfn),
    .grant_o   (grant_o)
  );

  assign rd_mask_o = (grant_o && is_rd) ? '1 : '0;

  always_comb begin
    cfg_rdata_o = '0;
    if (req_i && cfg_sel_i && is_rd) begin
      unique case (cfg_off)
        CFG_XLK: cfg_rdata_o = CFG_W'(xlk);
        CFG_WLK: cfg_rdata_o = CFG_W'(wlk);
        CFG_RFN: cfg_rdata_o = CFG_W'(rfn);
        default: cfg_rdata_o = CFG_W'(DEV_ID);
      endcase
    end
  end

  // R2
  wlock_deny_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !cfg_sel_i && acc == ACC_TWR && !wlk[tgt_idx]) |-> !grant_o);

  // R3
  fence_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !cfg_sel_i && acc == ACC_TRD && !rfn[tgt_idx] && pc_idx != tgt_idx)
      |-> (rd_mask_o == '0));

  // R4
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (!grant_o && rd_mask_o == '0 && cfg_rdata_o == '0));

  // R8
  int_erase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_req_i && !erase_ext_i && !cfg_wr) |=> ($stable(xlk) && $stable(wlk) && $stable(rfn)));
endmodule

// File: tb/sim_flash_guard.sv
module sim_flash_guard;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  acc = '0;
  logic        cs = 1'b0;
  logic [14:0] addr = '0, pc = '0;
  logic [4:0]  wd = '0;
  logic        er = 1'b0, ex = 1'b0, ea = 1'b0;
  logic [2:0]  eb = '0;
  logic        grant;
  logic [15:0] mask;
  logic [7:0]  crd;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [4:0] m_x = '1, m_w = '1, m_r = '1;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_guard u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .acc_type_i(acc), .cfg_sel_i(cs),
    .addr_i(addr), .pc_i(pc), .wdata_i(wd), .erase_req_i(er), .erase_ext_i(ex),
    .erase_all_i(ea), .erase_blk_i(eb), .grant_o(grant), .rd_mask_o(mask),
    .cfg_rdata_o(crd)
  );

  function automatic int region(input logic [14:0] a);
    int r;
    if (a < 15'h0800) return 4;
    r = (int'(a) - 'h800) / 'h1E00;
    return (r > 3) ? 3 : r;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic rq, input logic [1:0] at,
                      input logic c, input logic [14:0] a, input logic [14:0] p,
                      input logic [4:0] d, input logic e_r, input logic e_x,
                      input logic e_a, input logic [2:0] e_b);
    int t;
    logic eg;
    logic [7:0] ec;
    string tg;
    req = rq; acc = at; cs = c; addr = a; pc = p; wd = d;
    er = e_r; ex = e_x; ea = e_a; eb = e_b;
    #1;
    t = region(a);
    eg = 1'b0;
    if (rq) begin
      if (c) eg = 1'b1;
      else case (at)
        2'd0: eg = m_r[t] || (region(p) == t);
        2'd1: eg = m_w[t];
        default: eg = m_x[t];
      endcase
    end
    ec = '0;
    if (rq && c && !at[0]) case (a[1:0])
      2'd0: ec = {3'b0, m_x};
      2'd1: ec = {3'b0, m_w};
      2'd2: ec = {3'b0, m_r};
      default: ec = 8'h5A;
    endcase
    tg = tag;
    if (tg == "") begin
      if (!rq) tg = "R4";
      else if (c) tg = "R6";
      else if (at == 2'd0) tg = "R3";
      else if (at == 2'd1) tg = "R2";
      else tg = "R5";
    end
    chk(tg, "grant", grant, eg);
    chk(tg, "rd_mask R4", mask, (eg && !at[0]) ? 16'hFFFF : 16'h0);
    chk(tg, "cfg_rdata", crd, ec);
    @(posedge clk);
    if (e_r && e_x) begin
      if (e_a) begin m_x = '1; m_w = '1; m_r = '1; end
      else if (e_b <= 3'd4) begin m_x[e_b] = 1'b1; m_w[e_b] = 1'b1; m_r[e_b] = 1'b1; end
    end else if (rq && c && at[0]) begin
      case (a[1:0])
        2'd0: m_x = m_x & d;
        2'd1: m_w = m_w & d;
        2'd2: m_r = m_r & d;
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic cfg_wr(input string tag, input logic [1:0] off, input logic [4:0] d);
    step(tag, 1, 2'd1, 1, {13'b0, off}, 15'h0, d, 0, 0, 0, 0);
  endtask

  task automatic cfg_rd(input string tag, input logic [1:0] off);
    step(tag, 1, 2'd0, 1, {13'b0, off}, 15'h0, 5'h0, 0, 0, 0, 0);
  endtask

  task automatic acc_do(input string tag, input logic [1:0] at, input logic [14:0] a,
                        input logic [14:0] p);
    step(tag, 1, at, 0, a, p, 5'h0, 0, 0, 0, 0);
  endtask

  task automatic erase(input string tag, input logic e_x, input logic e_a, input logic [2:0] e_b);
    step(tag, 0, 2'd0, 0, 15'h0, 15'h0, 5'h0, 1, e_x, e_a, e_b);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    cfg_rd("R9", 2'd0); cfg_rd("R9", 2'd1); cfg_rd("R9", 2'd2); cfg_rd("R6", 2'd3);
    // R1 / R3 fence region 1 (0x2600..0x43FF)
    cfg_wr("R6", 2'd2, 5'h1D);
    cfg_rd("R9", 2'd2);
    acc_do("R1", 2'd0, 15'h2600, 15'h0100);
    acc_do("R1", 2'd0, 15'h25FF, 15'h0100);
    acc_do("R3", 2'd0, 15'h2600, 15'h43FF);
    acc_do("R1", 2'd0, 15'h4400, 15'h43FF);
    acc_do("R3", 2'd0, 15'h43FF, 15'h4400);
    // R2 write-lock boot
    cfg_wr("R2", 2'd1, 5'h0F);
    acc_do("R2", 2'd1, 15'h07FF, 15'h0000);
    acc_do("R1", 2'd1, 15'h0800, 15'h0000);
    acc_do("R5", 2'd3, 15'h07FF, 15'h0000);
    // R6 one-way and ignored id write
    cfg_wr("R6", 2'd1, 5'h1F);
    cfg_rd("R6", 2'd1);
    cfg_wr("R6", 2'd3, 5'h00);
    cfg_rd("R6", 2'd3);
    // R5 external lock on region 0
    cfg_wr("R5", 2'd0, 5'h1E);
    acc_do("R5", 2'd2, 15'h0800, 15'h0000);
    acc_do("R5", 2'd3, 15'h0800, 15'h0000);
    acc_do("R5", 2'd0, 15'h0800, 15'h5000);
    acc_do("R5", 2'd1, 15'h0800, 15'h5000);
    // R8 internal erase ignored
    erase("R8", 0, 1, 3'd0);
    cfg_rd("R8", 2'd0); cfg_rd("R8", 2'd1); cfg_rd("R8", 2'd2);
    // R7 region erases, out-of-range index, full erase
    erase("R7", 1, 0, 3'd4);
    cfg_rd("R7", 2'd1);
    erase("R7", 1, 0, 3'd1);
    cfg_rd("R7", 2'd2);
    erase("R7", 1, 0, 3'd6);
    cfg_rd("R7", 2'd0);
    erase("R7", 1, 1, 3'd0);
    cfg_rd("R7", 2'd0);
    // R10 erase beats same-cycle write
    step("R10", 1, 2'd3, 1, 15'h0000, 15'h0, 5'h00, 1, 1, 1, 3'd0);
    cfg_rd("R10", 2'd0);
    // R4 idle
    step("R4", 0, 2'd2, 0, 15'h1234, 15'h0, 5'h0, 0, 0, 0, 0);
    // random traffic against model
    for (int i = 0; i < 4000; i++) begin
      logic rq, c, e_r;
      rq  = ($urandom_range(0, 7) != 0);
      c   = ($urandom_range(0, 5) == 0);
      e_r = ($urandom_range(0, 60) == 0);
      step("", rq, 2'($urandom_range(0, 3)), c, 15'($urandom_range(0, 32767)),
           15'($urandom_range(0, 32767)), 5'($urandom_range(0, 31) | 16),
           e_r, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           3'($urandom_range(0, 7)));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule